// File: doc/BRIEF.md
# Banked Memory Mapper Register File

This block sits on the cartridge side of an 8-bit CPU bus with a 16-bit address. CPU writes to the upper 32 KB are decoded into a small set of bank, mirroring and layout registers. Those registers then steer two address translators, both purely combinational. The first maps the 32 KB program area onto a program ROM through four 8 KB windows. The second maps the 8 KB video pattern space onto a character ROM through eight 1 KB windows.

Two of the program windows are switchable. The first switchable bank can sit at either the lowest or the third window, depending on a layout bit, and the other of those two windows then shows the second-last bank. The top window always shows the last bank. Character bank numbers are eight bits wide and are written one nibble at a time. A strap input selects whether the write decode compares all sixteen address lines or only a reduced set, so that partially decoded boards are supported.

Top module: `bank_mapper_regs`

## Requirements
- R1: After reset, the program windows 0..3 show banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1. Character register i holds i, mirror_o is 0 and the layout bit is clear.
- R2: A write to 0x8000, 0x8004, 0x8008 or 0x800C loads the switchable bank A. While the layout bit is clear, bank A appears in window 0 (cpu_addr_i[14:13]=0). While the layout bit is set, it appears in window 2.
- R3: A write to 0x9008 stores data bit 1 as the layout bit. While the bit is set, window 0 shows bank PRG_BANKS-2 and window 2 shows bank A. While it is clear, window 2 shows PRG_BANKS-2.
- R4: A write to 0xA000, 0xA004, 0xA008 or 0xA00C loads bank B, which is shown in window 1.
- R5: Window 3 (cpu_addr_i[14:13]=3) always shows bank PRG_BANKS-1.
- R6: A write to 0x9000 sets mirror_o to data[1:0]. The codes are 0 vertical, 1 horizontal, 2 single-screen low and 3 single-screen high.
- R7: A write of data 0xFF to 0x9000 leaves mirror_o unchanged.
- R8: Character registers form pairs (2k, 2k+1) at base 0xB000, 0xC000, 0xD000 and 0xE000 for k = 0..3. The base offset selects the target, and each write keeps the other nibble of the register:
  - offset 0x0 writes the low nibble of register 2k;
  - offset 0x1 or 0x4 writes the high nibble of register 2k;
  - offset 0x2 or 0x8 writes the low nibble of register 2k+1;
  - offset 0x3 or 0xC writes the high nibble of register 2k+1.
- R9: prg_addr_o = {bank of window cpu_addr_i[14:13], cpu_addr_i[12:0]}. chr_addr_o = {register vid_addr_i[12:10], vid_addr_i[9:0]}.
- R10: With alt_mask_i low, all 16 address bits are compared, so 0xB005 matches nothing. With alt_mask_i high, the address is ANDed with 0xF00C before decode, so 0xB005 acts as 0xB004 and 0x9FF9 acts as 0x9008.
- R11: State changes only at a rising clock edge where wr_en_i is high. Writes below 0x8000 or to undecoded addresses change nothing. The outputs reflect a write right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, sampled at the rising edge |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| alt_mask_i | input | 1 | Selects the reduced decode mask 0xF00C |
| cpu_addr_i | input | 15 | CPU read address within the 32 KB program area |
| prg_addr_o | output | 21 | Program ROM address |
| vid_addr_i | input | 13 | Video pattern-space address |
| chr_addr_o | output | 18 | Character ROM address |
| mirror_o | output | 2 | Nametable mirroring code |

## Verification
A write is taken at the one rising edge where wr_en_i is sampled high. Every result depends on the registers only through combinational logic, so each result is due in the same cycle, right after that edge. The bench drives the write at a falling edge and removes it at the next falling edge. It then sets the probe address and samples 1 ns later, which is always after exactly one capturing edge. Ignored writes, a low strobe and the 0xFF mirroring case are observed through the same outputs in the same slot.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int BANK_W    = 8;
  localparam int DATA_W    = 8;
  localparam int PRG_OFF_W = 13;
  localparam int CHR_OFF_W = 10;
  localparam int NUM_CHR   = 8;
  localparam int CHR_SEL_W = $clog2(NUM_CHR);
  localparam int PRG_WIN_W = 2;

  localparam logic [15:0] MASK_FULL = 16'hFFFF;
  localparam logic [15:0] MASK_ALT  = 16'hF00C;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PRG_A,
    OP_PRG_B,
    OP_LAYOUT,
    OP_MIRROR,
    OP_CHR
  } op_e;

  typedef enum logic [1:0] {
    MIR_VERT,
    MIR_HORZ,
    MIR_ONE_LO,
    MIR_ONE_HI
  } mirror_e;

  typedef struct packed {
    op_e                  op;
    logic [CHR_SEL_W-1:0] chr_idx;
    logic                 chr_hi;
  } wr_cmd_t;
endpackage

// File: rtl/mapper_wr_decode.sv
module mapper_wr_decode
  import bank_mapper_pkg::*;
(
  input  logic        wr_en_i,
  input  logic [15:0] addr_i,
  input  logic        alt_mask_i,
  output wr_cmd_t     cmd_o
);
  logic [15:0] masked;
  logic [1:0]  pair;

  assign masked = addr_i & (alt_mask_i ? MASK_ALT : MASK_FULL);
  // B..E -> pair 0..3
  assign pair   = masked[13:12] - 2'd3;

  always_comb begin
    cmd_o.op      = OP_NONE;
    cmd_o.chr_idx = '0;
    cmd_o.chr_hi  = 1'b0;
    if (wr_en_i) begin
      unique case (masked[15:12])
        4'h8: if (masked[11:0] inside {12'h000, 12'h004, 12'h008, 12'h00C}) cmd_o.op = OP_PRG_A;
        4'h9: begin
          if (masked[11:0] == 12'h000) cmd_o.op = OP_MIRROR;
          else if (masked[11:0] == 12'h008) cmd_o.op = OP_LAYOUT;
        end
        4'hA: if (masked[11:0] inside {12'h000, 12'h004, 12'h008, 12'h00C}) cmd_o.op = OP_PRG_B;
        4'hB, 4'hC, 4'hD, 4'hE: begin
          unique case (masked[11:0])
            12'h000:          begin cmd_o.op = OP_CHR; cmd_o.chr_idx = {pair, 1'b0}; cmd_o.chr_hi = 1'b0; end
            12'h001, 12'h004: begin cmd_o.op = OP_CHR; cmd_o.chr_idx = {pair, 1'b0}; cmd_o.chr_hi = 1'b1; end
            12'h002, 12'h008: begin cmd_o.op = OP_CHR; cmd_o.chr_idx = {pair, 1'b1}; cmd_o.chr_hi = 1'b0; end
            12'h003, 12'h00C: begin cmd_o.op = OP_CHR; cmd_o.chr_idx = {pair, 1'b1}; cmd_o.chr_hi = 1'b1; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prg_bank_unit.sv
module prg_bank_unit
  import bank_mapper_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  localparam int PRG_AW   = BANK_W + PRG_OFF_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  wr_cmd_t              cmd_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic [14:0]          cpu_addr_i,
  output logic [PRG_AW-1:0]    prg_addr_o
);
  localparam logic [BANK_W-1:0] LAST_BANK   = BANK_W'(PRG_BANKS - 1);
  localparam logic [BANK_W-1:0] SECOND_BANK = BANK_W'(PRG_BANKS - 2);

  logic [BANK_W-1:0] bank_a_q, bank_b_q, bank_sel;
  logic              layout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_a_q <= '0;
      bank_b_q <= BANK_W'(1);
      layout_q <= 1'b0;
    end else begin
      unique case (cmd_i.op)
        OP_PRG_A:  bank_a_q <= data_i[BANK_W-1:0];
        OP_PRG_B:  bank_b_q <= data_i[BANK_W-1:0];
        OP_LAYOUT: layout_q <= data_i[1];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (cpu_addr_i[14:13])
      2'd0:    bank_sel = layout_q ? SECOND_BANK : bank_a_q;
      2'd1:    bank_sel = bank_b_q;
      2'd2:    bank_sel = layout_q ? bank_a_q : SECOND_BANK;
      default: bank_sel = LAST_BANK;
    endcase
  end

  assign prg_addr_o = {bank_sel, cpu_addr_i[PRG_OFF_W-1:0]};
endmodule

// File: rtl/chr_bank_file.sv
module chr_bank_file
  import bank_mapper_pkg::*;
#(
  localparam int CHR_AW = BANK_W + CHR_OFF_W,
  localparam int VID_W  = CHR_SEL_W + CHR_OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_cmd_t           cmd_i,
  input  logic [3:0]        nibble_i,
  input  logic [VID_W-1:0]  vid_addr_i,
  output logic [CHR_AW-1:0] chr_addr_o
);
  logic [NUM_CHR-1:0][BANK_W-1:0] bank_q;

  for (genvar i = 0; i < NUM_CHR; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_q[i] <= BANK_W'(i);
      end else if (cmd_i.op == OP_CHR && cmd_i.chr_idx == CHR_SEL_W'(i)) begin
        if (cmd_i.chr_hi) bank_q[i][7:4] <= nibble_i;
        else              bank_q[i][3:0] <= nibble_i;
      end
    end
  end

  assign chr_addr_o = {bank_q[vid_addr_i[VID_W-1:CHR_OFF_W]], vid_addr_i[CHR_OFF_W-1:0]};
endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
  import bank_mapper_pkg::*;
#(
  parameter int PRG_BANKS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        alt_mask_i,
  input  logic [14:0] cpu_addr_i,
  output logic [20:0] prg_addr_o,
  input  logic [12:0] vid_addr_i,
  output logic [17:0] chr_addr_o,
  output logic [1:0]  mirror_o
);
  wr_cmd_t cmd;
  mirror_e mirror_q;

  mapper_wr_decode u_dec (
    .wr_en_i   (wr_en_i),
    .addr_i    (wr_addr_i),
    .alt_mask_i(alt_mask_i),
    .cmd_o     (cmd)
  );

  prg_bank_unit #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .data_i    (wr_data_i),
    .cpu_addr_i(cpu_addr_i),
    .prg_addr_o(prg_addr_o)
  );

  chr_bank_file u_chr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .nibble_i  (wr_data_i[3:0]),
    .vid_addr_i(vid_addr_i),
    .chr_addr_o(chr_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mirror_q <= MIR_VERT;
    else if (cmd.op == OP_MIRROR && wr_data_i != 8'hFF) mirror_q <= mirror_e'(wr_data_i[1:0]);
  end

  assign mirror_o = mirror_q;
endmodule

// File: rtl/bank_mapper_regs_chk.sv
module bank_mapper_regs_chk #(
  parameter int PRG_BANKS = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_addr_i,
  input logic [7:0]  wr_data_i,
  input logic        alt_mask_i,
  input logic [14:0] cpu_addr_i,
  input logic [20:0] prg_addr_o,
  input logic [12:0] vid_addr_i,
  input logic [17:0] chr_addr_o,
  input logic [1:0]  mirror_o
);
  logic [15:0] masked;
  assign masked = wr_addr_i & (alt_mask_i ? 16'hF00C : 16'hFFFF);

  p_fixed_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[14:13] == 2'b11 |-> prg_addr_o[20:13] == 8'(PRG_BANKS - 1));

  p_prg_offset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_addr_o[12:0] == cpu_addr_i[12:0]);

  p_chr_offset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_addr_o[9:0] == vid_addr_i[9:0]);

  p_mirror_ff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && masked == 16'h9000 && wr_data_i == 8'hFF) |=> $stable(mirror_o));

  p_mirror_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mirror_o));

  p_prg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!$stable(cpu_addr_i) || $stable(prg_addr_o)));

  p_chr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!$stable(vid_addr_i) || $stable(chr_addr_o)));
endmodule

bind bank_mapper_regs bank_mapper_regs_chk #(.PRG_BANKS(PRG_BANKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .alt_mask_i(alt_mask_i),
  .cpu_addr_i(cpu_addr_i),
  .prg_addr_o(prg_addr_o),
  .vid_addr_i(vid_addr_i),
  .chr_addr_o(chr_addr_o),
  .mirror_o  (mirror_o)
);

// File: tb/tb_bank_mapper_regs.sv
module tb_bank_mapper_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        alt_mask = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic [12:0] vid_addr = '0;
  logic [20:0] prg_addr;
  logic [17:0] chr_addr;
  logic [1:0]  mirror;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bank_mapper_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .alt_mask_i(alt_mask), .cpu_addr_i(cpu_addr),
    .prg_addr_o(prg_addr), .vid_addr_i(vid_addr), .chr_addr_o(chr_addr),
    .mirror_o(mirror)
  );

  typedef struct packed {
    logic [15:0] wa;
    logic [7:0]  wd;
    logic        is_chr;
    logic [14:0] pa;
    logic [7:0]  bank;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h8000, 8'h05, 1'b0, 15'h0123, 8'h05, 4'd2},  // R2 window 0
    '{16'h8004, 8'h07, 1'b0, 15'h0000, 8'h07, 4'd2},  // R2 alias
    '{16'hA00C, 8'h09, 1'b0, 15'h2010, 8'h09, 4'd4},  // R4
    '{16'h9008, 8'h02, 1'b0, 15'h0000, 8'h1E, 4'd3},  // R3 set, window 0 pinned
    '{16'h0000, 8'h00, 1'b0, 15'h4004, 8'h07, 4'd3},  // R3 bank A moved to window 2
    '{16'h8008, 8'h0B, 1'b0, 15'h4000, 8'h0B, 4'd2},  // R2 load while layout set
    '{16'h9008, 8'hFD, 1'b0, 15'h0000, 8'h0B, 4'd3},  // R3 clear
    '{16'h0000, 8'h00, 1'b0, 15'h4000, 8'h1E, 4'd3},  // R3 window 2 pinned
    '{16'h800C, 8'hAA, 1'b0, 15'h61FF, 8'h1F, 4'd5},  // R5
    '{16'hB000, 8'h3C, 1'b1, 15'h0005, 8'h0C, 4'd8},  // R8 even low
    '{16'hB004, 8'h5A, 1'b1, 15'h0000, 8'hAC, 4'd8},  // R8 even high
    '{16'hB008, 8'h07, 1'b1, 15'h0400, 8'h07, 4'd8},  // R8 odd low
    '{16'hB003, 8'h0E, 1'b1, 15'h07FF, 8'hE7, 4'd8},  // R8 odd high, R9
    '{16'hE00C, 8'hF4, 1'b1, 15'h1C01, 8'h47, 4'd8},  // R8 pair 3
    '{16'hD001, 8'h09, 1'b1, 15'h1000, 8'h94, 4'd8},  // R8 pair 2
    '{16'hB005, 8'h0F, 1'b1, 15'h0000, 8'hAC, 4'd10}, // R10 full compare
    '{16'h7000, 8'h55, 1'b1, 15'h0800, 8'h02, 4'd11}  // R11 below 0x8000
  };

  task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_prg(input string tag, input logic [14:0] a, input logic [7:0] bank);
    cpu_addr = a; #1;
    check(tag, prg_addr, {bank, a[12:0]});
  endtask

  task automatic chk_chr(input string tag, input logic [12:0] v, input logic [7:0] bank);
    vid_addr = v; #1;
    check(tag, {3'b0, chr_addr}, {3'b0, bank, v[9:0]});
  endtask

  task automatic chk_mir(input string tag, input logic [1:0] exp);
    #1; check(tag, {19'b0, mirror}, {19'b0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_prg("R1 win0", 15'h0000, 8'h00);
    chk_prg("R1 win1", 15'h2000, 8'h01);
    chk_prg("R1 win2", 15'h4000, 8'h1E);
    chk_prg("R1 win3", 15'h6000, 8'h1F);
    for (int i = 0; i < 8; i++) chk_chr($sformatf("R1 chr%0d", i), 13'(i * 1024 + 3), 8'(i));
    chk_mir("R1 mirror", 2'd0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      if (VECS[i].is_chr)
        chk_chr($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].pa[12:0], VECS[i].bank);
      else
        chk_prg($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].pa, VECS[i].bank);
    end
    chk_prg("R2 win0 after 800C", 15'h0000, 8'hAA);

    // R6 / R7 mirroring
    wr(16'h9000, 8'h01); chk_mir("R6 horz", 2'd1);
    wr(16'h9000, 8'hFF); chk_mir("R7 ignore FF", 2'd1);
    wr(16'h9000, 8'h06); chk_mir("R6 one low", 2'd2);
    wr(16'h9000, 8'h03); chk_mir("R6 one high", 2'd3);
    wr(16'h9004, 8'h00); chk_mir("R10 no alias", 2'd3);
    wr(16'h9000, 8'h00); chk_mir("R6 vert", 2'd0);

    // R10 reduced mask
    alt_mask = 1'b1;
    wr(16'hB005, 8'h03); chk_chr("R10 B005 as B004", 13'h0000, 8'h3C);
    wr(16'h8FF0, 8'h21); chk_prg("R10 8FF0 as 8000", 15'h0000, 8'h21);
    wr(16'h9FF9, 8'hFF); chk_prg("R10 9FF9 as 9008", 15'h0000, 8'h1E);
    alt_mask = 1'b0;
    chk_prg("R10 layout set win2", 15'h4000, 8'h21);

    // R11 strobe low
    @(negedge clk);
    wr_addr = 16'h8000; wr_data = 8'h55;
    @(negedge clk);
    chk_prg("R11 strobe low", 15'h4000, 8'h21);

    // R1 reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk_prg("R1 re-reset win0", 15'h0000, 8'h00);
    chk_chr("R1 re-reset chr0", 13'h0000, 8'h00);
    chk_mir("R1 re-reset mirror", 2'd0);

    finish_run();
  end
endmodule